// File: doc/BRIEF.md
# Sklansky Parallel-Prefix Adder

This block adds two operands in a single combinational pass, with no clock and no state. Its carries come from a divide-and-conquer prefix tree. Each bit first forms a propagate term (the XOR of its two operand bits) and a generate term (their AND). A tree of two-input combining cells then forms, for every bit position, the group generate across all lower bits. The tree has ceil(log2 N) levels. At level `l`, every position whose index has bit `l` set combines with the top position of the block just below it. Because of this, the fan-out of a block's top signal doubles from one level to the next.

A combining cell whose result already reaches down to bit 0 produces only a group generate (a grey cell). Every other combining cell also produces a group propagate (a black cell). Each final group generate is the carry into the next bit. The sum bit is the propagate term XORed with that carry. The carry into bit 0 is fixed at zero.

The two operands may have different widths. The internal width N is the larger of the two, and the narrower operand is widened to N bits. A mode parameter selects how the top result bit is formed: either as an unsigned carry-out or as a signed sign-extension bit. With either setting the (N+1)-bit result never overflows.

Top module: `sk_adder`

## Requirements
- R1: The internal width N equals the larger of parameters `WA` and `WB`, and `sum_o` is N+1 bits wide.
- R2: With `SIGNED`=0, the narrower operand is zero-extended, and `sum_o` equals the unsigned sum of the two operands. The carry-out of bit N-1 appears in bit N.
- R3: With `SIGNED`=1, the narrower operand is sign-extended (its top bit is copied), and `sum_o` is the two's-complement sum at N+1 bits. Bit N equals the XOR of the two extended top bits and the carry out of bit N-1.
- R4: There is no carry-in. Bit 0 of `sum_o` is the XOR of the two operand bit 0s, and two zero operands give a zero result.
- R5: The result is combinational. It follows a change of the operands within the same clock cycle and depends on no earlier input.
- R6: A carry formed at bit 0 propagates through every position up to bit N. For example, all-ones plus one gives 2^N in unsigned mode and zero in signed mode.
- R7: In signed mode, the most negative value plus the most negative value gives -2^N, with bit N set and all lower bits clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WA | First operand |
| op_b | input | WB | Second operand |
| sum_o | output | N+1 | Sum, N = max(WA, WB) |

## Verification
The bound checker re-evaluates the result whenever the operands change. It compares the whole result against a plain arithmetic sum of the extended operands, and it checks bit 0 against the operand LSBs. It also checks the top bit in two cases: when both operands share a sign in signed mode, and when both MSBs are set in unsigned mode. The bench shows the rest. It checks that the result settles within the same cycle as a change of inputs. It sweeps every operand pair for a small width in both modes. It drives carries that ripple across the whole tree, and the most-negative corner. Mismatched operand widths are covered in both extension modes.

// File: rtl/sk_adder_pkg.sv
package sk_adder_pkg;

  function automatic int max_w(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

  // number of prefix levels: ceil(log2(n)), 0 for a single bit
  function automatic int tree_levels(input int n);
    int l;
    l = 0;
    while ((1 << l) < n) l++;
    return l;
  endfunction

  // position i takes part at level lv when bit lv of its index is set
  function automatic bit combines(input int i, input int lv);
    return ((i >> lv) & 1) == 1;
  endfunction

  // top index of the block directly below the one holding i at level lv
  function automatic int split_src(input int i, input int lv);
    return ((i >> lv) << lv) - 1;
  endfunction

  // combine finishes the prefix down to bit 0: only a group generate is needed
  function automatic bit is_final(input int i, input int lv);
    return i < (2 << lv);
  endfunction

endpackage

// File: rtl/sk_pg_cell.sv
module sk_pg_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic p_o,
  output logic g_o,
  output logic s_o
);
  assign p_o = a_i ^ b_i;
  assign g_o = a_i & b_i;
  assign s_o = p_o ^ c_i;
endmodule

// File: rtl/sk_grey_cell.sv
module sk_grey_cell (
  input  logic g_hi_i,
  input  logic p_hi_i,
  input  logic g_lo_i,
  output logic g_o
);
  assign g_o = g_hi_i | (p_hi_i & g_lo_i);
endmodule

// File: rtl/sk_black_cell.sv
module sk_black_cell (
  input  logic g_hi_i,
  input  logic p_hi_i,
  input  logic g_lo_i,
  input  logic p_lo_i,
  output logic g_o,
  output logic p_o
);
  assign g_o = g_hi_i | (p_hi_i & g_lo_i);
  assign p_o = p_hi_i & p_lo_i;
endmodule

// File: rtl/sk_prefix_tree.sv
module sk_prefix_tree
  import sk_adder_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0] g_i,
  input  logic [N-1:0] p_i,
  output logic [N-1:0] grp_g_o
);
  localparam int LV = tree_levels(N);

  logic [N-1:0] g_lv [0:LV];
  logic [N-1:0] p_lv [0:LV];

  assign g_lv[0] = g_i;
  assign p_lv[0] = p_i;

  for (genvar lv = 0; lv < LV; lv++) begin : g_level
    for (genvar i = 0; i < N; i++) begin : g_pos
      if (combines(i, lv)) begin : g_join
        localparam int SRC = split_src(i, lv);
        if (is_final(i, lv)) begin : g_grey
          sk_grey_cell u_grey (
            .g_hi_i (g_lv[lv][i]),
            .p_hi_i (p_lv[lv][i]),
            .g_lo_i (g_lv[lv][SRC]),
            .g_o    (g_lv[lv+1][i])
          );
          assign p_lv[lv+1][i] = p_lv[lv][i];
        end else begin : g_black
          sk_black_cell u_black (
            .g_hi_i (g_lv[lv][i]),
            .p_hi_i (p_lv[lv][i]),
            .g_lo_i (g_lv[lv][SRC]),
            .p_lo_i (p_lv[lv][SRC]),
            .g_o    (g_lv[lv+1][i]),
            .p_o    (p_lv[lv+1][i])
          );
        end
      end else begin : g_pass
        assign g_lv[lv+1][i] = g_lv[lv][i];
        assign p_lv[lv+1][i] = p_lv[lv][i];
      end
    end
  end

  assign grp_g_o = g_lv[LV];

endmodule

// File: rtl/sk_adder.sv
module sk_adder
  import sk_adder_pkg::*;
#(
  parameter int WA     = 16,
  parameter int WB     = 16,
  parameter bit SIGNED = 1'b0,
  localparam int N     = max_w(WA, WB)
) (
  input  logic [WA-1:0] op_a,
  input  logic [WB-1:0] op_b,
  output logic [N:0]    sum_o
);
  logic [N-1:0] ax, bx, prop, gen, grp_g, carry;
  logic         cout;

  // operand widening
  if (WA < N) begin : g_ext_a
    assign ax = {{(N-WA){SIGNED ? op_a[WA-1] : 1'b0}}, op_a};
  end else begin : g_keep_a
    assign ax = op_a;
  end

  if (WB < N) begin : g_ext_b
    assign bx = {{(N-WB){SIGNED ? op_b[WB-1] : 1'b0}}, op_b};
  end else begin : g_keep_b
    assign bx = op_b;
  end

  // per-bit propagate/generate and sum
  for (genvar i = 0; i < N; i++) begin : g_bit
    sk_pg_cell u_pg (
      .a_i (ax[i]),
      .b_i (bx[i]),
      .c_i (carry[i]),
      .p_o (prop[i]),
      .g_o (gen[i]),
      .s_o (sum_o[i])
    );
  end

  sk_prefix_tree #(.N(N)) u_tree (
    .g_i     (gen),
    .p_i     (prop),
    .grp_g_o (grp_g)
  );

  // carry into bit 0 is a constant zero
  if (N > 1) begin : g_carry
    assign carry = {grp_g[N-2:0], 1'b0};
  end else begin : g_carry1
    assign carry = 1'b0;
  end

  assign cout = grp_g[N-1];

  if (SIGNED) begin : g_top_s
    assign sum_o[N] = ax[N-1] ^ bx[N-1] ^ cout;
  end else begin : g_top_u
    assign sum_o[N] = cout;
  end

endmodule

// File: rtl/sk_adder_chk.sv
module sk_adder_chk
  import sk_adder_pkg::*;
#(
  parameter int WA     = 16,
  parameter int WB     = 16,
  parameter bit SIGNED = 1'b0,
  localparam int N     = max_w(WA, WB)
) (
  input logic [WA-1:0] op_a,
  input logic [WB-1:0] op_b,
  input logic [N:0]    sum_o
);
  logic [N:0] ea, eb, ref_sum;

  always_comb begin
    ea = SIGNED ? (N+1)'($signed(op_a)) : (N+1)'(op_a);
    eb = SIGNED ? (N+1)'($signed(op_b)) : (N+1)'(op_b);
    ref_sum = ea + eb;
  end

  always_comb begin
    if (!$isunknown({op_a, op_b})) begin
      // R2 R3
      sum_ref_chk: assert (sum_o == ref_sum)
        else $error("sum mismatch");
      // R4
      lsb_no_cin_chk: assert (sum_o[0] == (op_a[0] ^ op_b[0]))
        else $error("bit 0 mismatch");
      // R3
      sign_same_chk: assert (!(SIGNED && (ea[N-1] == eb[N-1])) || (sum_o[N] == ea[N-1]))
        else $error("sign bit mismatch");
      // R2
      carry_out_chk: assert (!(!SIGNED && ea[N-1] && eb[N-1]) || sum_o[N])
        else $error("carry out missing");
    end
  end
endmodule

bind sk_adder sk_adder_chk #(.WA(WA), .WB(WB), .SIGNED(SIGNED)) u_chk (
  .op_a  (op_a),
  .op_b  (op_b),
  .sum_o (sum_o)
);

// File: tb/sk_adder_tb.sv
module sk_adder_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0]  a85;  logic [4:0]  b85;
  logic [8:0]  s85_s, s85_u;
  logic [3:0]  a4, b4;
  logic [4:0]  s4_s, s4_u;
  logic [15:0] a16;  logic [11:0] b16;
  logic [16:0] s16;

  sk_adder #(.WA(8),  .WB(5),  .SIGNED(1'b1)) u_dut     (.op_a(a85), .op_b(b85), .sum_o(s85_s));
  sk_adder #(.WA(8),  .WB(5),  .SIGNED(1'b0)) u_dut_u85 (.op_a(a85), .op_b(b85), .sum_o(s85_u));
  sk_adder #(.WA(4),  .WB(4),  .SIGNED(1'b1)) u_dut_s4  (.op_a(a4),  .op_b(b4),  .sum_o(s4_s));
  sk_adder #(.WA(4),  .WB(4),  .SIGNED(1'b0)) u_dut_u4  (.op_a(a4),  .op_b(b4),  .sum_o(s4_u));
  sk_adder #(.WA(16), .WB(12), .SIGNED(1'b1)) u_dut_s16 (.op_a(a16), .op_b(b16), .sum_o(s16));

  // a[30:23] b[22:18] signed result[17:9] unsigned result[8:0]
  localparam int NV = 6;
  localparam logic [30:0] VEC [NV] = '{
    {8'h7F, 5'h0F, 9'h08E, 9'h08E},
    {8'h80, 5'h10, 9'h170, 9'h090},
    {8'hFF, 5'h01, 9'h000, 9'h100},
    {8'h00, 5'h1F, 9'h1FF, 9'h01F},
    {8'h55, 5'h0A, 9'h05F, 9'h05F},
    {8'h80, 5'h00, 9'h180, 9'h080}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    a85 = '0; b85 = '0; a4 = '0; b4 = '0; a16 = '0; b16 = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R4: zero operands, zero result
    chk("R4 zero", 32'(s85_s), 32'h0);
    chk("R4 zero", 32'(s16), 32'h0);
    // R1: result width is max width + 1
    chk("R1 width", 32'($bits(s85_s)), 32'd9);
    chk("R1 width", 32'($bits(s16)), 32'd17);

    // R2 R3: table walk, mismatched widths
    for (int k = 0; k < NV; k++) begin
      @(posedge clk);
      a85 = VEC[k][30:23]; b85 = VEC[k][22:18];
      @(negedge clk);
      chk("R3 table", 32'(s85_s), 32'(VEC[k][17:9]));
      chk("R2 table", 32'(s85_u), 32'(VEC[k][8:0]));
    end

    // R2 R3 R4: exhaustive 4-bit both modes
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        @(posedge clk);
        a4 = 4'(x); b4 = 4'(y);
        @(negedge clk);
        chk("R3 sweep", 32'(s4_s), 32'(5'({a4[3], a4} + {b4[3], b4})));
        chk("R2 sweep", 32'(s4_u), 32'(5'({1'b0, a4} + {1'b0, b4})));
        chk("R4 lsb", 32'(s4_u[0]), 32'(a4[0] ^ b4[0]));
      end
    end

    // R6: carry ripples across every position
    @(posedge clk); a4 = 4'hF; b4 = 4'h1;
    @(negedge clk);
    chk("R6 ripple u", 32'(s4_u), 32'h10);
    chk("R6 ripple s", 32'(s4_s), 32'h00);
    @(posedge clk); a16 = 16'hFFFF; b16 = 12'h001;
    @(negedge clk);
    chk("R6 ripple 16", 32'(s16), 32'h0);
    // R2: all ones
    @(posedge clk); a4 = 4'hF; b4 = 4'hF;
    @(negedge clk);
    chk("R2 ones", 32'(s4_u), 32'h1E);
    // R7: most negative twice
    @(posedge clk); a4 = 4'h8; b4 = 4'h8;
    @(negedge clk);
    chk("R7 minneg", 32'(s4_s), 32'h10);
    @(posedge clk); a16 = 16'h8000; b16 = 12'h800;
    @(negedge clk);
    chk("R7 minneg 16", 32'(s16), 32'h17800);

    // R5: result follows inputs within the cycle, no history
    @(posedge clk); a85 = 8'h01; b85 = 5'h01;
    #1;
    chk("R5 same cycle", 32'(s85_u), 32'h002);
    a85 = 8'h10;
    #1;
    chk("R5 same cycle", 32'(s85_u), 32'h011);

    // R3: random 16x12 signed
    for (int r = 0; r < 400; r++) begin
      @(posedge clk);
      a16 = 16'($urandom); b16 = 12'($urandom);
      @(negedge clk);
      chk("R3 random", 32'(s16), 32'(17'({a16[15], a16} + {{5{b16[11]}}, b16})));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule